// File: doc/BRIEF.md
# Width-Configurable Accumulator ALU

This block is the arithmetic and logic unit for the accumulator and index registers of a processor core. A 2-bit size code picks the operating width for each operation (8, 16 or 32 bits). The block takes two operands, an 8-bit immediate, and the incoming carry and overflow flags. It returns the result together with negative, overflow, carry and zero flags. The register file writes the result back whole. Bits above the selected width come back exactly as they were in the first operand, so a narrow operation never disturbs the rest of the register.

The set of operations is as follows:
- Addition and subtraction, each with and without the incoming carry.
- Two's-complement negation.
- The three bitwise logic functions.
- A step up or down by an immediate plus one.
- A zero-extending byte load.
- Two in-register swaps: the halves of the full word, or the two bytes of the low half.

All of the work is done in one combinational pass. Results and flags are captured in output registers one clock after the request.

Top module: `alu_accum`

## Requirements
- R1: When `in_valid` is high on a rising edge, `out_valid`, `result` and the four flags present that operation after that edge. `out_valid` is low after any edge where `in_valid` was low. A synchronous reset clears `out_valid`, `result` and all flags to 0.
- R2: The size code selects the operating width. Code 00 selects 8 bits and code 01 selects 16 bits. Codes 10 and 11 both select 32 bits.
- R3: ADD (op 0) adds `opnd_a` and `opnd_b` and ignores `carry_in`. ADC (op 1) also adds `carry_in`.
- R4: SUB (op 2) computes `opnd_a - opnd_b` as if `carry_in` were 1. SBC (op 3) computes `opnd_a + ~opnd_b + carry_in`. For both, C=1 means no borrow occurred.
- R5: NEG (op 4) returns `0 - opnd_a` within the width. C is 1 only when that field of `opnd_a` is zero. V is 1 only when the field holds the most negative value.
- R6: AND (op 5), OR (op 6) and XOR (op 7) combine `opnd_a` and `opnd_b` bit by bit within the width.
- R7: INC (op 8) adds `imm + 1` to `opnd_a`, and DEC (op 9) subtracts `imm + 1` from it. Both wrap modulo the width.
- R8: LDZ (op 10) places `imm`, zero-extended, into the selected width.
- R9: Two swaps ignore the size code when forming the result. Word swap (op 11) exchanges bits 31:16 with bits 15:0. Byte swap (op 12) exchanges bits 15:8 with bits 7:0 and keeps bits 31:16.
- R10: For all operations other than the two swaps, result bits above the selected width equal the same bits of `opnd_a`.
- R11: For ops 0 to 4, C is the carry out of the top bit of the selected width. V flags signed overflow at that width.
- R12: N equals the top bit of the selected width of `result`. Z is 1 exactly when every result bit inside the selected width is 0.
- R13: For ops 5 to 12, `flag_c` equals `carry_in` and `flag_v` equals `ovf_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Operation code (0..12) |
| size | input | 2 | Width code: 00=8, 01=16, 1x=32 |
| opnd_a | input | 32 | Register operand, also the source of pass-through bits |
| opnd_b | input | 32 | Second operand |
| imm | input | 8 | Immediate for step and byte load |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Full-width result |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry / no borrow |
| flag_z | output | 1 | Zero within width |

## Verification
The hardest case to reach is a narrow operation whose carry or overflow comes from bit 7 or bit 15 while the upper operand bits are busy. For example, an 8-bit add whose carry would ripple into nonzero pass-through bits. Only the flag output shows whether the carry was taken at the right place. The stimulus therefore pairs narrow sizes with operands that have distinctive upper halves and boundary low fields (0x7F+1, 0xFF+1, 0x80 negated, zero negated). It also covers the swaps at narrow sizes, where the size code shapes the flags but not the result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_SZ = 3;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_NEG = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_LDZ = 4'd10,
    OP_SWW = 4'd11,
    OP_SWB = 4'd12
  } alu_op_e;
endpackage

// File: rtl/alu_width_sel.sv
module alu_width_sel #(
  parameter int W = 32
) (
  input  logic [1:0]                 size,
  output logic [alu_pkg::NUM_SZ-1:0] sel,
  output logic [W-1:0]               mask
);
  localparam int QW = W / 4;
  localparam int HW = W / 2;

  always_comb begin
    case (size)
      2'b00:   sel = 3'b001;
      2'b01:   sel = 3'b010;
      default: sel = 3'b100;
    endcase
    if (sel[0])      mask = {{(W-QW){1'b0}}, {QW{1'b1}}};
    else if (sel[1]) mask = {{(W-HW){1'b0}}, {HW{1'b1}}};
    else             mask = {W{1'b1}};
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0]               a,
  input  logic [W-1:0]               b,
  input  logic                       cin,
  input  logic [alu_pkg::NUM_SZ-1:0] sel,
  output logic [W-1:0]               sum,
  output logic                       cout,
  output logic                       ovf
);
  logic [W:0]                 s;
  logic [alu_pkg::NUM_SZ-1:0] co;
  logic [alu_pkg::NUM_SZ-1:0] ci_top;

  assign s   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum = s[W-1:0];

  for (genvar i = 0; i < alu_pkg::NUM_SZ; i++) begin : g_lane
    localparam int LW = W >> (alu_pkg::NUM_SZ - 1 - i);
    assign ci_top[i] = s[LW-1] ^ a[LW-1] ^ b[LW-1];
    if (LW == W) begin : g_full
      assign co[i] = s[W];
    end else begin : g_part
      assign co[i] = s[LW] ^ a[LW] ^ b[LW];
    end
  end

  assign cout = |(sel & co);
  assign ovf  = |(sel & (co ^ ci_top));
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  alu_pkg::alu_op_e            op,
  input  logic [W-1:0]                a,
  input  logic [W-1:0]                b,
  input  logic [alu_pkg::BYTE_W-1:0]  imm,
  output logic [W-1:0]                y
);
  import alu_pkg::*;
  localparam int HW = W / 2;

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_LDZ:  y = {{(W-BYTE_W){1'b0}}, imm};
      OP_SWW:  y = {a[HW-1:0], a[W-1:HW]};
      OP_SWB:  y = {a[W-1:HW], a[BYTE_W-1:0], a[HW-1:BYTE_W]};
      default: y = a;
    endcase
  end
endmodule

// File: rtl/alu_accum.sv
module alu_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [1:0]   size,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [7:0]   imm,
  input  logic         carry_in,
  input  logic         ovf_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_c,
  output logic         flag_z
);
  import alu_pkg::*;
  localparam int QW = W / 4;
  localparam int HW = W / 2;

  alu_op_e            op_e;
  logic [NUM_SZ-1:0]  sel;
  logic [W-1:0]       mask;
  logic [W-1:0]       add_a, add_b, step, sum, lg_y, raw, res;
  logic               add_ci, add_co, add_ov, is_arith, is_swap;
  logic               c_nxt, v_nxt, n_nxt, z_nxt;

  assign op_e = alu_op_e'(op);
  assign step = {{(W-BYTE_W){1'b0}}, imm} + {{(W-1){1'b0}}, 1'b1};

  alu_width_sel #(.W(W)) u_wsel (.size(size), .sel(sel), .mask(mask));

  always_comb begin
    add_a    = opnd_a;
    add_b    = opnd_b;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    case (op_e)
      OP_ADD: add_ci = 1'b0;
      OP_ADC: add_ci = carry_in;
      OP_SUB: begin add_b = ~opnd_b; add_ci = 1'b1;     end
      OP_SBC: begin add_b = ~opnd_b; add_ci = carry_in; end
      OP_NEG: begin add_a = '0; add_b = ~opnd_a; add_ci = 1'b1; end
      OP_INC: add_b = step;
      OP_DEC: begin add_b = ~step; add_ci = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci), .sel(sel),
    .sum(sum), .cout(add_co), .ovf(add_ov)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op_e), .a(opnd_a), .b(opnd_b), .imm(imm), .y(lg_y)
  );

  assign is_swap = (op_e == OP_SWW) || (op_e == OP_SWB);
  assign raw     = is_arith ? sum : lg_y;
  assign res     = is_swap ? raw : ((raw & mask) | (opnd_a & ~mask));

  // Flags with C/V only from the arithmetic ops that define them
  always_comb begin
    n_nxt = |(sel & {res[W-1], res[HW-1], res[QW-1]});
    z_nxt = ~|(res & mask);
    if (op_e <= OP_NEG) begin
      c_nxt = add_co;
      v_nxt = add_ov;
    end else begin
      c_nxt = carry_in;
      v_nxt = ovf_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res;
        flag_n <= n_nxt;
        flag_v <= v_nxt;
        flag_c <= c_nxt;
        flag_z <= z_nxt;
      end
    end
  end
endmodule

// File: rtl/alu_accum_chk.sv
module alu_accum_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic [1:0]   size,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         carry_in,
  input logic         ovf_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         flag_v,
  input logic         flag_c,
  input logic         flag_z
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_ADD_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd0 && size[1]) |=> (result == $past(opnd_a) + $past(opnd_b))); // R3
  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd4 && size[1]) |=> (flag_c == ($past(opnd_a) == '0))); // R5
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == 2'b00 && op != 4'd11 && op != 4'd12)
      |=> (result[W-1:8] == $past(opnd_a[W-1:8]))); // R10
  AST_ZERO_NARROW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == 2'b00) |=> (flag_z == (result[7:0] == 8'h00))); // R12
  AST_CV_HELD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd5) |=> (flag_c == $past(carry_in) && flag_v == $past(ovf_in))); // R13
endmodule

bind alu_accum alu_accum_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .ovf_in(ovf_in),
  .out_valid(out_valid), .result(result), .flag_v(flag_v), .flag_c(flag_c),
  .flag_z(flag_z)
);

// File: tb/alu_accum_tb_top.sv
`timescale 1ns/1ps
module alu_accum_tb_top;
  typedef struct {
    logic [31:0] res;
    logic [3:0]  nvcz;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  imm = '0;
  logic        carry_in = 1'b0, ovf_in = 1'b0;
  logic        out_valid, flag_n, flag_v, flag_c, flag_z;
  logic [31:0] result;

  int   applied = 0;
  int   miscompares = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  alu_accum dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .carry_in(carry_in),
    .ovf_in(ovf_in), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z)
  );

  task automatic fail(string tag, logic [31:0] got, logic [3:0] gf,
                      logic [31:0] want, logic [3:0] wf);
    miscompares++;
    $display("FAIL %s: got res=%h nvcz=%b, expected res=%h nvcz=%b",
             tag, got, gf, want, wf);
  endtask

  // Reference model from the requirements
  task automatic drive(input logic [3:0] o, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] im, input logic ci, input logic vi,
                       input string tag);
    int          w;
    logic [31:0] m, ea, eb, rf, r;
    logic [63:0] t;
    logic        n, v, c, z;
    exp_t        e;
    w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    c  = ci;
    v  = vi;
    rf = '0;
    if (o <= 4'd4) begin
      logic ec;
      ea = a; eb = b; ec = 1'b0;
      case (o)
        4'd1: ec = ci;
        4'd2: begin eb = ~b; ec = 1'b1; end
        4'd3: begin eb = ~b; ec = ci;   end
        4'd4: begin ea = '0; eb = ~a; ec = 1'b1; end
        default: ec = 1'b0;
      endcase
      ea = ea & m; eb = eb & m;
      t  = {32'd0, ea} + {32'd0, eb} + {63'd0, ec};
      rf = t[31:0] & m;
      c  = t[w];
      v  = (ea[w-1] == eb[w-1]) && (rf[w-1] != ea[w-1]);
    end else begin
      case (o)
        4'd5:  rf = a & b;
        4'd6:  rf = a | b;
        4'd7:  rf = a ^ b;
        4'd8:  rf = a + {24'd0, im} + 32'd1;
        4'd9:  rf = a - {24'd0, im} - 32'd1;
        4'd10: rf = {24'd0, im};
        default: rf = a;
      endcase
      rf = rf & m;
    end
    if (o == 4'd11)      r = {a[15:0], a[31:16]};
    else if (o == 4'd12) r = {a[31:16], a[7:0], a[15:8]};
    else                 r = (a & ~m) | rf;
    n = r[w-1];
    z = ((r & m) == 32'd0);
    e.res = r; e.nvcz = {n, v, c, z}; e.tag = tag;
    @(negedge clk);
    op = o; size = sz; opnd_a = a; opnd_b = b; imm = im;
    carry_in = ci; ovf_in = vi; in_valid = 1'b1;
    sb.push_back(e);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    applied++;
    if (out_valid !== 1'b0) fail("R1 idle", {31'd0, out_valid}, 4'h0, 32'd0, 4'h0);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      applied++;
      if (sb.size() == 0) begin
        fail("R1 unexpected", result, {flag_n, flag_v, flag_c, flag_z}, 32'd0, 4'h0);
      end else begin
        e = sb.pop_front();
        if (result !== e.res || {flag_n, flag_v, flag_c, flag_z} !== e.nvcz)
          fail(e.tag, result, {flag_n, flag_v, flag_c, flag_z}, e.res, e.nvcz);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    applied++;
    if (out_valid !== 1'b0 || result !== 32'd0 || {flag_n, flag_v, flag_c, flag_z} !== 4'h0)
      fail("R1 reset", result, {flag_n, flag_v, flag_c, flag_z}, 32'd0, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    // widths and add forms
    drive(4'd0, 2'b00, 32'h1234_56F0, 32'h0000_0020, 8'h00, 1'b1, 1'b0, "R3 R2 R10 add8 carry");
    drive(4'd0, 2'b00, 32'hAB00_007F, 32'h0000_0001, 8'h00, 1'b0, 1'b0, "R11 add8 ovf");
    drive(4'd0, 2'b01, 32'h5555_FFFF, 32'h0000_0001, 8'h00, 1'b1, 1'b0, "R2 R12 add16 zero");
    drive(4'd0, 2'b10, 32'h7FFF_FFFF, 32'h0000_0001, 8'h00, 1'b1, 1'b0, "R3 add32 ovf");
    drive(4'd0, 2'b11, 32'h8000_0000, 32'h8000_0000, 8'h00, 1'b0, 1'b0, "R2 size11 add");
    drive(4'd1, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000, 8'h00, 1'b1, 1'b0, "R3 adc32 wrap");
    drive(4'd1, 2'b00, 32'h0000_1010, 32'h0000_0101, 8'h00, 1'b1, 1'b0, "R3 adc8");
    // subtract forms
    drive(4'd2, 2'b01, 32'hFFFF_0005, 32'h0000_0007, 8'h00, 1'b0, 1'b0, "R4 sub16 borrow");
    drive(4'd2, 2'b00, 32'h0000_0080, 32'h0000_0001, 8'h00, 1'b0, 1'b0, "R4 R11 sub8 ovf");
    drive(4'd3, 2'b10, 32'h0000_0010, 32'h0000_0005, 8'h00, 1'b0, 1'b0, "R4 sbc32 cin0");
    drive(4'd3, 2'b10, 32'h0000_0010, 32'h0000_0005, 8'h00, 1'b1, 1'b0, "R4 sbc32 cin1");
    // negate
    drive(4'd4, 2'b00, 32'hCAFE_0080, 32'h0, 8'h00, 1'b0, 1'b0, "R5 neg8 min");
    drive(4'd4, 2'b10, 32'h0000_0000, 32'h0, 8'h00, 1'b0, 1'b1, "R5 neg32 zero");
    drive(4'd4, 2'b01, 32'h1234_0001, 32'h0, 8'h00, 1'b1, 1'b0, "R5 neg16 one");
    // logic
    drive(4'd5, 2'b01, 32'hF0F0_F0F0, 32'h0FF0_FF00, 8'h00, 1'b1, 1'b1, "R6 R13 and16");
    drive(4'd6, 2'b00, 32'h1200_0000, 32'h00FF_0080, 8'h00, 1'b0, 1'b1, "R6 or8");
    drive(4'd7, 2'b10, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'h00, 1'b1, 1'b0, "R6 xor32 zero");
    // step and load
    drive(4'd8, 2'b00, 32'h1234_56FF, 32'h0, 8'h00, 1'b1, 1'b1, "R7 R13 inc8 wrap");
    drive(4'd8, 2'b10, 32'h0000_0100, 32'h0, 8'hFF, 1'b0, 1'b0, "R7 inc32 imm255");
    drive(4'd9, 2'b01, 32'h9999_0001, 32'h0, 8'h02, 1'b0, 1'b1, "R7 dec16 under");
    drive(4'd10, 2'b01, 32'hDEAD_BEEF, 32'h0, 8'hAB, 1'b1, 1'b0, "R8 ldz16");
    drive(4'd10, 2'b00, 32'hDEAD_BEEF, 32'h0, 8'h00, 1'b0, 1'b1, "R8 ldz8 zero");
    // swaps
    drive(4'd11, 2'b00, 32'h1122_3344, 32'h0, 8'h00, 1'b1, 1'b1, "R9 sww size8");
    drive(4'd11, 2'b10, 32'h0000_8000, 32'h0, 8'h00, 1'b0, 1'b0, "R9 sww32 neg");
    drive(4'd12, 2'b01, 32'hAABB_0080, 32'h0, 8'h00, 1'b1, 1'b0, "R9 swb16");
    idle_check();
    drive(4'd0, 2'b00, 32'hFFFF_FF00, 32'h0000_0000, 8'h00, 1'b1, 1'b0, "R12 add8 zero");
    idle_check();
    applied++;
    if (sb.size() != 0) fail("R1 pending", 32'(sb.size()), 4'h0, 32'd0, 4'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule